// File: doc/BRIEF.md
# Configurable UART Transmit Engine

This block turns bytes into an asynchronous serial stream. Bytes are written into a sixteen-entry holding queue. Whenever the serialiser is idle, transmission is enabled and no line break is requested, the oldest byte is taken and sent as one frame. The frame has a low start bit, seven or eight data bits sent least significant first, an optional odd or even parity bit and one or two high stop bits. Every bit lasts sixteen pulses of a baud tick input, which runs at sixteen times the bit rate.

A control word selects the frame format at run time. The block samples that format at the start of each frame, so a change made during a frame takes effect on the next one. The same word can request a break: the line is driven low for a programmed number of bit times, a completion pulse is raised, and the line then idles high until the request is withdrawn. A loopback option diverts the serial stream to a separate output and keeps the external line idle. Single-cycle event outputs report the end of a frame, an underrun, the queue draining to empty or to the low-water mark, and the end of a break.

Top module: `uart_tx_engine`

## Requirements
- R1: The queue holds 16 bytes. A write (`wr_en` high) is accepted only when fewer than 16 bytes are held, and a write to a full queue is dropped. `fifo_count` shows the number of held bytes, 0 to 16, and changes on the clock edge that samples the write or the removal.
- R2: A frame is a start bit (0), then the data bits least significant first, then the parity bit when `lcr[4]`=1, then the stop bits (1). There are 8 data bits when `lcr[2]`=1 and 7 (bits 6..0) when it is 0. Parity makes the count of ones over data and parity odd when `lcr[5]`=1 and even when it is 0. There are two stop bits when `lcr[3]`=1 and one when it is 0. Each bit lasts 16 `baud_tick` pulses. The format is sampled on the edge that starts the frame.
- R3: With `lcr[0]`=0 no new frame starts and held bytes stay in the queue, but a frame already running completes. Writes are still accepted.
- R4: A frame starts on the clock edge that finds the serialiser idle, `lcr[0]`=1, the queue non-empty and no break requested or active. The start bit appears on `tx_out` right after that edge. Back-to-back frames are separated by one clock of idle.
- R5: `irq_idle` pulses high for one cycle right after the edge ending a frame's last stop bit. `irq_underrun` pulses in the same cycle when the queue was empty at that edge and `lcr[0]`=1.
- R6: `irq_empty` is high for one cycle, the first cycle in which `fifo_count` reads 0 after being non-zero. `irq_low_water` is high for one cycle, the first cycle in which `fifo_count` is 4 or less after being above 4.
- R7: Setting `lcr[9]` requests a break. The break waits for a running frame to end and then drives the line low for `brk_len` bit times (a value of 0 acts as 1). It then releases the line high and pulses `irq_break_done` for one cycle. No frame starts while `lcr[9]`=1, and a new break needs `lcr[9]` to be cleared and set again.
- R8: Clearing `lcr[9]` ends the break request. A break still in progress stops on the first edge that samples it clear, so the line is high in the next cycle, and frames resume.
- R9: With `lcr[7]`=1, `tx_out` is held high and `loop_out` carries the serial stream. With `lcr[7]`=0, `loop_out` is held high.
- R10: `rts_out` follows `lcr[6]`.
- R11: After reset `tx_out` and `loop_out` are high, `fifo_count` is 0 and every event output is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Push `wr_data` into the queue |
| wr_data | input | 8 | Byte to send |
| lcr | input | 10 | Line control word (enable, format, RTS, loopback, break) |
| brk_len | input | 16 | Break length in bit times |
| baud_tick | input | 1 | One-cycle pulse at 16x the bit rate |
| tx_out | output | 1 | Serial output, idle high |
| loop_out | output | 1 | Serial stream when loopback is on, else high |
| rts_out | output | 1 | Request-to-send level |
| fifo_count | output | 5 | Bytes held in the queue |
| irq_idle | output | 1 | Frame finished pulse |
| irq_low_water | output | 1 | Queue fell to the low-water mark pulse |
| irq_empty | output | 1 | Queue became empty pulse |
| irq_underrun | output | 1 | Frame finished with nothing to follow pulse |
| irq_break_done | output | 1 | Break completed pulse |

## Verification
The assertions assume that `baud_tick` is a single-cycle pulse train and that `wr_en`, `wr_data`, `lcr` and `brk_len` change only between clock edges. They place no limit on when `lcr` changes relative to a frame. The bench changes every input on the falling clock edge. It runs the tick at two rates, including one pulse every clock, and it deliberately changes the format, the enable bit and the break request in the middle of frames, so that the capture and wait rules are exercised within those assumptions.

// File: rtl/uart_tx_pkg.sv
package uart_tx_pkg;
   localparam int LCW       = 10;
   localparam int LC_TXEN   = 0;
   localparam int LC_CS8    = 2;
   localparam int LC_STOP2  = 3;
   localparam int LC_PAREN  = 4;
   localparam int LC_PARODD = 5;
   localparam int LC_RTS    = 6;
   localparam int LC_LOOP   = 7;
   localparam int LC_BRK    = 9;

   typedef enum logic [1:0] {
      BRK_IDLE = 2'd0,
      BRK_LOW  = 2'd1,
      BRK_HELD = 2'd2
   } brk_state_t;

   typedef struct packed {
      logic cs8;
      logic stop2;
      logic par_en;
      logic par_odd;
   } frame_cfg_t;
endpackage

// File: rtl/uart_tx_fifo.sv
module uart_tx_fifo #(
   parameter int DEPTH = 16,
   parameter int WIDTH = 8,
   localparam int AW = $clog2(DEPTH),
   localparam int CW = $clog2(DEPTH + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             push,
   input  logic [WIDTH-1:0] din,
   input  logic             pop,
   output logic [WIDTH-1:0] dout,
   output logic [CW-1:0]    count,
   output logic             empty,
   output logic             full
);
   generate
      if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
         $error("uart_tx_fifo: DEPTH must be a power of two of at least 2");
      end
      if (WIDTH < 1) begin : g_bad_width
         $error("uart_tx_fifo: WIDTH must be positive");
      end
   endgenerate

   logic [WIDTH-1:0] mem [DEPTH];
   logic [AW-1:0]    wr_ptr, rd_ptr;
   logic [CW-1:0]    cnt_q;

   assign count = cnt_q;
   assign empty = (cnt_q == '0);
   assign full  = (cnt_q == CW'(DEPTH));
   assign dout  = mem[rd_ptr];

   always_ff @(posedge clk) begin
      if (push) mem[wr_ptr] <= din;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         cnt_q  <= '0;
      end else begin
         if (push) wr_ptr <= wr_ptr + 1'b1;
         if (pop)  rd_ptr <= rd_ptr + 1'b1;
         case ({push, pop})
            2'b10:   cnt_q <= cnt_q + 1'b1;
            2'b01:   cnt_q <= cnt_q - 1'b1;
            default: cnt_q <= cnt_q;
         endcase
      end
   end

   AST_POP_NONEMPTY: assert property (@(posedge clk) disable iff (!rst_n)
      pop |-> !empty); // R1
   AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      push |-> !full); // R1
   AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt_q != $past(cnt_q)) |->
         ((cnt_q == $past(cnt_q) + 1'b1) || (cnt_q == $past(cnt_q) - 1'b1))); // R1
endmodule

// File: rtl/uart_tx_shifter.sv
module uart_tx_shifter import uart_tx_pkg::*; #(
   parameter int DW    = 8,
   parameter int TICKS = 16,
   localparam int FB = DW + 4,
   localparam int IW = $clog2(FB),
   localparam int TW = $clog2(TICKS)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          tick,
   input  logic          start,
   input  logic [DW-1:0] data,
   input  frame_cfg_t    cfg,
   output logic          busy,
   output logic          line,
   output logic          frame_done
);
   generate
      if (DW < 2) begin : g_bad_dw
         $error("uart_tx_shifter: DW must be at least 2");
      end
      if (TICKS < 2) begin : g_bad_ticks
         $error("uart_tx_shifter: TICKS must be at least 2");
      end
   endgenerate

   logic [FB-1:0] fr;
   logic [IW-1:0] nbits_m1;
   logic          par;

   // Frame image: bit 0 goes out first; unused top bits stay at stop level.
   always_comb begin
      fr    = '1;
      fr[0] = 1'b0;
      par   = cfg.par_odd;
      for (int i = 0; i < DW; i++) begin
         if (i < DW - 1 || cfg.cs8) begin
            fr[1+i] = data[i];
            par     = par ^ data[i];
         end
      end
      if (cfg.par_en) begin
         if (cfg.cs8) fr[DW+1] = par;
         else         fr[DW]   = par;
      end
      nbits_m1 = IW'((cfg.cs8 ? DW : DW - 1) + int'(cfg.par_en) + int'(cfg.stop2) + 1);
   end

   logic [FB-1:0] sr;
   logic [IW-1:0] idx, last;
   logic [TW-1:0] tcnt;
   logic          busy_q;
   logic          step;

   assign busy       = busy_q;
   assign line       = sr[0];
   assign step       = busy_q & tick & (tcnt == TW'(TICKS - 1));
   assign frame_done = step & (idx == last);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sr     <= '1;
         idx    <= '0;
         last   <= '0;
         tcnt   <= '0;
         busy_q <= 1'b0;
      end else if (start) begin
         sr     <= fr;
         idx    <= '0;
         last   <= nbits_m1;
         tcnt   <= '0;
         busy_q <= 1'b1;
      end else if (busy_q && tick) begin
         if (tcnt == TW'(TICKS - 1)) begin
            tcnt <= '0;
            if (idx == last) begin
               busy_q <= 1'b0;
               sr     <= '1;
            end else begin
               idx <= idx + 1'b1;
               sr  <= {1'b1, sr[FB-1:1]};
            end
         end else begin
            tcnt <= tcnt + 1'b1;
         end
      end
   end

   AST_START_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy_q) |-> !line); // R2
   AST_STOP_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
      frame_done |-> line); // R2
   AST_START_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      start |-> !busy_q); // R4
endmodule

// File: rtl/uart_tx_break.sv
module uart_tx_break import uart_tx_pkg::*; #(
   parameter int TICKS = 16,
   parameter int LW    = 16,
   localparam int TW = $clog2(TICKS)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          tick,
   input  logic          req,
   input  logic          shifter_busy,
   input  logic [LW-1:0] len,
   output logic          hold_low,
   output logic          block,
   output logic          done
);
   generate
      if (LW < 1) begin : g_bad_lw
         $error("uart_tx_break: LW must be positive");
      end
   endgenerate

   brk_state_t    state;
   logic [TW-1:0] tcnt;
   logic [LW-1:0] elapsed;
   logic [LW:0]   eff;
   logic          bit_end;

   assign eff      = (len == '0) ? (LW+1)'(1) : {1'b0, len};
   assign bit_end  = (state == BRK_LOW) & req & tick & (tcnt == TW'(TICKS - 1));
   assign done     = bit_end & (({1'b0, elapsed} + (LW+1)'(1)) >= eff);
   assign hold_low = (state == BRK_LOW);
   assign block    = req | (state == BRK_LOW);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state   <= BRK_IDLE;
         tcnt    <= '0;
         elapsed <= '0;
      end else begin
         case (state)
            BRK_IDLE: begin
               if (req && !shifter_busy) begin
                  state   <= BRK_LOW;
                  tcnt    <= '0;
                  elapsed <= '0;
               end
            end
            BRK_LOW: begin
               if (!req) begin
                  state <= BRK_IDLE;
               end else if (tick) begin
                  if (tcnt == TW'(TICKS - 1)) begin
                     tcnt <= '0;
                     if (done) state   <= BRK_HELD;
                     else      elapsed <= elapsed + 1'b1;
                  end else begin
                     tcnt <= tcnt + 1'b1;
                  end
               end
            end
            BRK_HELD: begin
               if (!req) state <= BRK_IDLE;
            end
            default: state <= BRK_IDLE;
         endcase
      end
   end

   AST_BRK_WAITS: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(hold_low) |-> $past(!shifter_busy)); // R7
   AST_BRK_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
      !req |=> !hold_low); // R8
endmodule

// File: rtl/uart_tx_engine.sv
module uart_tx_engine import uart_tx_pkg::*; #(
   parameter int DEPTH    = 16,
   parameter int DW       = 8,
   parameter int TICKS    = 16,
   parameter int AE_LEVEL = 4,
   parameter int BRK_W    = 16,
   localparam int CW = $clog2(DEPTH + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [DW-1:0]    wr_data,
   input  logic [LCW-1:0]   lcr,
   input  logic [BRK_W-1:0] brk_len,
   input  logic             baud_tick,
   output logic             tx_out,
   output logic             loop_out,
   output logic             rts_out,
   output logic [CW-1:0]    fifo_count,
   output logic             irq_idle,
   output logic             irq_low_water,
   output logic             irq_empty,
   output logic             irq_underrun,
   output logic             irq_break_done
);
   generate
      if (AE_LEVEL < 0 || AE_LEVEL >= DEPTH) begin : g_bad_ae
         $error("uart_tx_engine: AE_LEVEL must lie below DEPTH");
      end
   endgenerate

   logic          lcr_unused;
   assign lcr_unused = ^{lcr[1], lcr[8]};

   logic          push, pop, q_empty, q_full;
   logic [DW-1:0] q_data;
   logic          sh_busy, sh_line, sh_done;
   logic          brk_low, brk_block, brk_done;
   frame_cfg_t    cfg;

   assign cfg  = '{cs8: lcr[LC_CS8], stop2: lcr[LC_STOP2],
                   par_en: lcr[LC_PAREN], par_odd: lcr[LC_PARODD]};
   assign push = wr_en & ~q_full;
   assign pop  = ~sh_busy & lcr[LC_TXEN] & ~q_empty & ~brk_block;

   uart_tx_fifo #(.DEPTH(DEPTH), .WIDTH(DW)) i_fifo (
      .clk(clk), .rst_n(rst_n), .push(push), .din(wr_data), .pop(pop),
      .dout(q_data), .count(fifo_count), .empty(q_empty), .full(q_full)
   );

   uart_tx_shifter #(.DW(DW), .TICKS(TICKS)) i_shifter (
      .clk(clk), .rst_n(rst_n), .tick(baud_tick), .start(pop), .data(q_data),
      .cfg(cfg), .busy(sh_busy), .line(sh_line), .frame_done(sh_done)
   );

   uart_tx_break #(.TICKS(TICKS), .LW(BRK_W)) i_break (
      .clk(clk), .rst_n(rst_n), .tick(baud_tick), .req(lcr[LC_BRK]),
      .shifter_busy(sh_busy), .len(brk_len), .hold_low(brk_low),
      .block(brk_block), .done(brk_done)
   );

   logic line_int;
   assign line_int = brk_low ? 1'b0 : sh_line;
   assign tx_out   = lcr[LC_LOOP] ? 1'b1 : line_int;
   assign loop_out = lcr[LC_LOOP] ? line_int : 1'b1;
   assign rts_out  = lcr[LC_RTS];

   logic [CW-1:0] cnt_prev;
   logic          idle_q, udr_q, bkd_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_prev <= '0;
         idle_q   <= 1'b0;
         udr_q    <= 1'b0;
         bkd_q    <= 1'b0;
      end else begin
         cnt_prev <= fifo_count;
         idle_q   <= sh_done;
         udr_q    <= sh_done & q_empty & lcr[LC_TXEN];
         bkd_q    <= brk_done;
      end
   end

   assign irq_idle       = idle_q;
   assign irq_underrun   = udr_q;
   assign irq_break_done = bkd_q;
   assign irq_empty      = (fifo_count == '0) & (cnt_prev != '0);
   assign irq_low_water  = (fifo_count <= CW'(AE_LEVEL)) & (cnt_prev > CW'(AE_LEVEL));

   AST_UDR_WITH_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      irq_underrun |-> irq_idle); // R5
   AST_NO_START_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
      !lcr[LC_TXEN] |=> !$rose(sh_busy)); // R3
   AST_BKDONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      irq_break_done |=> !irq_break_done); // R7
   AST_NO_START_IN_BREAK: assert property (@(posedge clk) disable iff (!rst_n)
      lcr[LC_BRK] |=> !$rose(sh_busy)); // R7
endmodule

// File: tb/test_uart_tx_engine.sv
module test_uart_tx_engine;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [7:0]  wr_data = '0;
   logic [9:0]  lcr = '0;
   logic [15:0] brk_len = 16'd3;
   logic        baud_tick = 1'b0;
   logic        tx_out, loop_out, rts_out;
   logic [4:0]  fifo_count;
   logic        irq_idle, irq_low_water, irq_empty, irq_underrun, irq_break_done;

   localparam logic [9:0] TXEN = 10'd1, CS8 = 10'd4, STOP2 = 10'd8, PAREN = 10'd16,
                          PARODD = 10'd32, RTS = 10'd64, LOOP = 10'd128, BRK = 10'd512;

   uart_tx_engine i_uart_tx_engine (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .lcr(lcr),
      .brk_len(brk_len), .baud_tick(baud_tick), .tx_out(tx_out), .loop_out(loop_out),
      .rts_out(rts_out), .fifo_count(fifo_count), .irq_idle(irq_idle),
      .irq_low_water(irq_low_water), .irq_empty(irq_empty), .irq_underrun(irq_underrun),
      .irq_break_done(irq_break_done)
   );

   always #10ns clk = ~clk;

   int tests = 0;
   int fails = 0;
   int cyc = 0;
   bit run_cmp = 1'b0;
   int n_idle = 0, n_udr = 0, n_empty = 0, n_lw = 0, n_bkd = 0;

   task automatic chk(input string tag, input int act, input int expv);
      tests++;
      if (act != expv) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", tag, act, expv, cyc);
      end
   endtask

   task automatic finish_up;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   endtask

   // baud tick generator: one pulse every (tick_div+1) clocks
   int tick_div = 0;
   int tick_cnt = 0;
   always @(negedge clk) begin
      if (tick_cnt >= tick_div) begin
         baud_tick = 1'b1;
         tick_cnt  = 0;
      end else begin
         baud_tick = 1'b0;
         tick_cnt++;
      end
   end

   // behavioural reference model
   logic [7:0]  m_q[$];
   bit          m_busy = 0;
   bit [11:0]   m_bits;
   int          m_nbits = 0, m_idx = 0, m_tick = 0;
   bit          m_line = 1;
   int          m_brk = 0, m_btick = 0, m_bel = 0;
   bit          e_idle = 0, e_udr = 0, e_empty = 0, e_lw = 0, e_bkd = 0;

   always @(posedge clk) begin : model
      int old_sz, new_sz, nd, eff, brk_pre;
      bit full, done, busy_pre, p;
      logic [7:0] d;
      if (!rst_n) begin
         m_q.delete();
         m_busy = 0; m_line = 1; m_idx = 0; m_tick = 0; m_nbits = 0;
         m_brk = 0; m_btick = 0; m_bel = 0;
         e_idle = 0; e_udr = 0; e_empty = 0; e_lw = 0; e_bkd = 0;
      end else begin
         old_sz   = m_q.size();
         full     = (old_sz == 16);
         done     = 0;
         busy_pre = m_busy;
         brk_pre  = m_brk;
         e_bkd    = 0;
         if (m_busy) begin
            if (baud_tick) begin
               if (m_tick == 15) begin
                  m_tick = 0;
                  if (m_idx == m_nbits - 1) begin
                     done = 1; m_busy = 0; m_line = 1;
                  end else begin
                     m_idx++; m_line = m_bits[m_idx];
                  end
               end else m_tick++;
            end
         end else if (lcr[0] && old_sz > 0 && !lcr[9] && brk_pre != 1) begin
            d = m_q.pop_front();
            nd = lcr[2] ? 8 : 7;
            m_bits = '1;
            m_bits[0] = 1'b0;
            p = 0;
            for (int i = 0; i < nd; i++) begin
               m_bits[1+i] = d[i];
               p = p ^ d[i];
            end
            m_nbits = 1 + nd;
            if (lcr[4]) begin
               m_bits[m_nbits] = lcr[5] ? ~p : p;
               m_nbits++;
            end
            m_nbits = m_nbits + (lcr[3] ? 2 : 1);
            m_idx = 0; m_tick = 0; m_line = 0; m_busy = 1;
         end
         case (brk_pre)
            0: if (lcr[9] && !busy_pre) begin m_brk = 1; m_btick = 0; m_bel = 0; end
            1: begin
               if (!lcr[9]) m_brk = 0;
               else if (baud_tick) begin
                  if (m_btick == 15) begin
                     m_btick = 0;
                     eff = (brk_len == 0) ? 1 : int'(brk_len);
                     if (m_bel + 1 >= eff) begin m_brk = 2; e_bkd = 1; end
                     else m_bel++;
                  end else m_btick++;
               end
            end
            default: if (!lcr[9]) m_brk = 0;
         endcase
         e_idle = done;
         e_udr  = done && (old_sz == 0) && lcr[0];
         if (wr_en && !full) m_q.push_back(wr_data);
         new_sz  = m_q.size();
         e_empty = (new_sz == 0) && (old_sz != 0);
         e_lw    = (new_sz <= 4) && (old_sz > 4);
      end
   end

   // per-cycle comparison, away from the active edge
   always @(posedge clk) begin : compare
      bit ln;
      #5ns;
      if (rst_n && run_cmp) begin
         ln = (m_brk == 1) ? 1'b0 : m_line;
         chk("R2/R4/R7 tx_out", int'(tx_out), lcr[7] ? 1 : int'(ln));
         chk("R9 loop_out", int'(loop_out), lcr[7] ? int'(ln) : 1);
         chk("R10 rts_out", int'(rts_out), int'(lcr[6]));
         chk("R1 fifo_count", int'(fifo_count), m_q.size());
         chk("R5 irq_idle", int'(irq_idle), int'(e_idle));
         chk("R5 irq_underrun", int'(irq_underrun), int'(e_udr));
         chk("R6 irq_empty", int'(irq_empty), int'(e_empty));
         chk("R6 irq_low_water", int'(irq_low_water), int'(e_lw));
         chk("R7 irq_break_done", int'(irq_break_done), int'(e_bkd));
         n_idle  += int'(irq_idle);
         n_udr   += int'(irq_underrun);
         n_empty += int'(irq_empty);
         n_lw    += int'(irq_low_water);
         n_bkd   += int'(irq_break_done);
      end
   end

   always @(posedge clk) begin
      cyc++;
      if (cyc == 150000) begin
         fails++;
         $display("FAIL R4 watchdog actual=%0d expected<%0d", cyc, 150000);
         finish_up();
      end
   end

   task automatic write_bytes(input int n, input int seed);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         wr_en   = 1'b1;
         wr_data = 8'((seed + i * 37) & 8'hff);
      end
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic set_lcr(input logic [9:0] v);
      @(negedge clk);
      lcr = v;
   endtask

   task automatic wait_idle;
      int k;
      k = 0;
      while ((m_busy || m_q.size() != 0) && k < 20000) begin
         @(posedge clk);
         k++;
      end
      repeat (4) @(posedge clk);
   endtask

   task automatic sample;
      @(posedge clk);
      #5ns;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n   = 1'b1;
      run_cmp = 1'b1;
      sample();
      chk("R11 tx_out after reset", int'(tx_out), 1);
      chk("R11 loop_out after reset", int'(loop_out), 1);
      chk("R11 fifo_count after reset", int'(fifo_count), 0);
      chk("R11 events after reset",
          int'({irq_idle, irq_low_water, irq_empty, irq_underrun, irq_break_done}), 0);

      // fill while disabled, two writes beyond capacity
      write_bytes(18, 5);
      sample();
      chk("R1 full queue drops extra writes", int'(fifo_count), 16);
      repeat (50) @(posedge clk);
      #5ns;
      chk("R3 disabled keeps bytes", int'(fifo_count), 16);
      chk("R3 disabled line idle", int'(tx_out), 1);

      // drain as 8N1 with one tick per clock
      set_lcr(TXEN | CS8);
      wait_idle();
      chk("R1 drained", int'(fifo_count), 0);
      chk("R5 frame pulses", n_idle, 16);
      chk("R5 one underrun", n_udr, 1);
      chk("R6 one empty pulse", n_empty, 1);
      chk("R6 one low-water pulse", n_lw, 1);

      // 7 data bits, even parity, two stop bits
      set_lcr(TXEN | PAREN | STOP2);
      write_bytes(3, 8'h55);
      wait_idle();

      // 8 data bits, odd parity, slower tick, format changed mid-frame
      tick_div = 2;
      set_lcr(TXEN | CS8 | PAREN | PARODD);
      write_bytes(2, 8'ha5);
      repeat (40) @(posedge clk);
      set_lcr(TXEN | CS8 | STOP2);
      wait_idle();
      tick_div = 0;

      // enable cleared during a frame: it completes, the next waits
      set_lcr(TXEN | CS8);
      write_bytes(2, 8'h3c);
      repeat (50) @(posedge clk);
      set_lcr(CS8);
      repeat (400) @(posedge clk);
      #5ns;
      chk("R3 second byte held", int'(fifo_count), 1);
      chk("R3 line idle when disabled", int'(tx_out), 1);
      set_lcr(TXEN | CS8);
      wait_idle();

      // break requested during a frame
      write_bytes(1, 8'h0f);
      repeat (20) @(posedge clk);
      brk_len = 16'd3;
      set_lcr(TXEN | CS8 | BRK);
      repeat (300) @(posedge clk);
      #5ns;
      chk("R7 line high after break", int'(tx_out), 1);
      chk("R7 one break done pulse", n_bkd, 1);
      write_bytes(1, 8'hc3);
      repeat (200) @(posedge clk);
      #5ns;
      chk("R7 no frame while break requested", int'(fifo_count), 1);
      set_lcr(TXEN | CS8);
      wait_idle();
      chk("R8 frames resume", int'(fifo_count), 0);

      // long break aborted
      brk_len = 16'd100;
      set_lcr(TXEN | CS8 | BRK);
      repeat (40) @(posedge clk);
      #5ns;
      chk("R7 line low during break", int'(tx_out), 0);
      set_lcr(TXEN | CS8);
      sample();
      chk("R8 abort releases line", int'(tx_out), 1);
      chk("R8 no done pulse on abort", n_bkd, 1);

      // zero length acts as one bit time
      brk_len = 16'd0;
      set_lcr(TXEN | CS8 | BRK);
      repeat (40) @(posedge clk);
      #5ns;
      chk("R7 zero length completes", n_bkd, 2);
      set_lcr(TXEN | CS8);

      // loopback with RTS set
      set_lcr(TXEN | CS8 | LOOP | RTS);
      write_bytes(1, 8'h96);
      repeat (30) @(posedge clk);
      #5ns;
      chk("R9 tx_out held high in loopback", int'(tx_out), 1);
      chk("R10 rts follows control", int'(rts_out), 1);
      wait_idle();
      set_lcr(TXEN | CS8);
      sample();
      chk("R10 rts cleared", int'(rts_out), 0);
      chk("R9 loop_out idle outside loopback", int'(loop_out), 1);

      repeat (10) @(posedge clk);
      finish_up();
   end
endmodule